// File: doc/BRIEF.md
# Lockable Control Register Bank

This block holds the output-control state of a driver chip. An external serial slave front end turns frames into single-cycle register accesses, and this bank takes them through a synchronous write strobe with an address and data, and a combinational read port. The bank has four kinds of 16-bit register: a chip control word, a half-bridge control word, a high-side/heater/regulator control word, and six duty-cycle words. Each field drives the output logic next to the bank without further decoding.

The chip control word carries a 3-bit key. One key value locks the bank and another unlocks it. While the bank is locked, writes to every register except the chip control word are dropped. The same word has a fault-clear request bit that clears itself, and a watchdog-restart bit. The watchdog-restart bit acts when a write changes its value. Both produce single-cycle pulses for the fault logic and the watchdog timer outside the bank.

Top module: `ctl_reg_bank`

## Requirements
- R1: Writes are accepted at offsets 29h (chip control), 2Ah (half-bridge), 2Bh (high-side/heater/regulator) and 2Ch..31h (duty words 0..5). The written value reads back one cycle later, except for the fields named below. The half-bridge and high-side words keep all 16 bits.
- R2: A synchronous active-low reset returns every register to zero and the key to 011b. The chip control word then reads 0060h and the bank is unlocked.
- R3: While the bank is locked, writes to offsets 2Ah..31h leave their contents and outputs unchanged.
- R4: The key sits at bits 7:5 of the chip control word and is accepted while locked. Writing 110b locks the bank and 011b unlocks it. Any other key value leaves the key and the lock state as they were. The other fields of the same write are still taken.
- R5: When bit 0 of the chip control word is written as 1, the fault-clear pulse is high for exactly the following cycle. Bit 0 reads 1 in that cycle and 0 afterwards.
- R6: When a chip control write carries a bit 1 that differs from the stored bit 1, the watchdog-restart pulse is high in the following cycle. The new value is stored and reads back. A write of the same value gives no pulse.
- R7: Duty words store bits 9:0 and drive them on `duty_flat` (word k at bits 10k+9:10k). Bits 15:10 always read as zero.
- R8: Half-bridge output k uses bits 2k+1:2k. Code 01 drives the high-side enable, code 10 drives the low-side enable, and codes 00 and 11 drive neither. The high-side and low-side enables of the same output are never high together.
- R9: A read at any other offset returns zero. A write to any other offset changes no register.
- R10: The high-side word drives `hs_en` from bits 5:0, `heat_en` from bit 7, `ec_target` from bits 13:8, `ec_on` from bit 14 and `ec_discharge` from bit 15. Chip control bits 12:8 drive `sense_sel` and bit 13 drives `sense_in_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| hb_hs_on | output | 6 | Half-bridge high-side enables |
| hb_ls_on | output | 6 | Half-bridge low-side enables |
| gd_hiz | output | 2 | Gate driver pull-down requests (half-bridge bits 15:14) |
| gd_in | output | 2 | Gate driver software inputs (half-bridge bits 13:12) |
| hs_en | output | 6 | High-side driver enables |
| heat_en | output | 1 | Heater enable |
| ec_on | output | 1 | Regulator enable |
| ec_discharge | output | 1 | Regulator discharge enable |
| ec_target | output | 6 | Regulator target code |
| duty_flat | output | 60 | Six 10-bit duty values |
| sense_sel | output | 5 | Sense selector |
| sense_in_mode | output | 1 | Sense pin direction select |
| clr_flt_pulse | output | 1 | One-cycle fault-clear pulse |
| wd_restart_pulse | output | 1 | One-cycle watchdog-restart pulse |

## Verification
The bench builds the bank with its default parameters: six half-bridge outputs, six 10-bit duty words, and the offsets 29h..31h. These values place the edges of the decoded window (28h, 32h) and the duty words at both ends within reach of direct stimulus. A behavioural model tracks the key, the pulses and every register, and the bench compares it with all outputs and with the read port on every clock. Directed sequences cover locking, rejected keys while locked, watchdog toggles in both directions, reserved half-bridge codes, and a reset while the bank is locked.

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int ADDR_W = 8,
  parameter int N_HB = 6,
  parameter int N_HS = 6,
  parameter int N_DUTY = 6,
  parameter int DUTY_W = 10,
  parameter logic [ADDR_W-1:0] IC_ADDR = 8'h29,
  parameter logic [ADDR_W-1:0] HB_ADDR = 8'h2A,
  parameter logic [ADDR_W-1:0] HS_ADDR = 8'h2B,
  parameter logic [ADDR_W-1:0] DUTY_BASE = 8'h2C
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [15:0]              wdata,
  output logic [15:0]              rdata,
  output logic [N_HB-1:0]          hb_hs_on,
  output logic [N_HB-1:0]          hb_ls_on,
  output logic [1:0]               gd_hiz,
  output logic [1:0]               gd_in,
  output logic [N_HS-1:0]          hs_en,
  output logic                     heat_en,
  output logic                     ec_on,
  output logic                     ec_discharge,
  output logic [5:0]               ec_target,
  output logic [N_DUTY*DUTY_W-1:0] duty_flat,
  output logic [4:0]               sense_sel,
  output logic                     sense_in_mode,
  output logic                     clr_flt_pulse,
  output logic                     wd_restart_pulse
);
  localparam logic [2:0] KEY_OPEN = 3'b011;
  localparam logic [2:0] KEY_SHUT = 3'b110;

  logic [2:0]  key;
  logic        locked;
  logic        wd_bit;
  logic        clr_bit;
  logic        wd_pls;
  logic [4:0]  sel_q;
  logic        mode_q;
  logic [15:0] hb_q;
  logic [15:0] hs_q;
  logic [DUTY_W-1:0] duty_q [N_DUTY];
  logic wr_ic, wr_hb, wr_hs;

  assign locked = (key == KEY_SHUT);
  assign wr_ic  = wr_en && (addr == IC_ADDR);
  assign wr_hb  = wr_en && (addr == HB_ADDR) && !locked;
  assign wr_hs  = wr_en && (addr == HS_ADDR) && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key     <= KEY_OPEN;
      wd_bit  <= 1'b0;
      clr_bit <= 1'b0;
      wd_pls  <= 1'b0;
      sel_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      clr_bit <= wr_ic && wdata[0];
      wd_pls  <= wr_ic && (wdata[1] != wd_bit);
      if (wr_ic) begin
        if (wdata[7:5] == KEY_OPEN || wdata[7:5] == KEY_SHUT) key <= wdata[7:5];
        wd_bit <= wdata[1];
        sel_q  <= wdata[12:8];
        mode_q <= wdata[13];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_q <= '0;
      hs_q <= '0;
    end else begin
      if (wr_hb) hb_q <= wdata;
      if (wr_hs) hs_q <= wdata;
    end
  end

  for (genvar i = 0; i < N_DUTY; i++) begin : g_duty
    localparam logic [ADDR_W-1:0] A = ADDR_W'(DUTY_BASE + i);
    always_ff @(posedge clk) begin
      if (!rst_n) duty_q[i] <= '0;
      else if (wr_en && addr == A && !locked) duty_q[i] <= wdata[DUTY_W-1:0];
    end
    assign duty_flat[i*DUTY_W +: DUTY_W] = duty_q[i];
  end

  for (genvar k = 0; k < N_HB; k++) begin : g_hb
    assign hb_hs_on[k] = (hb_q[2*k +: 2] == 2'b01);
    assign hb_ls_on[k] = (hb_q[2*k +: 2] == 2'b10);
  end

  assign gd_hiz           = hb_q[15:14];
  assign gd_in            = hb_q[13:12];
  assign hs_en            = hs_q[N_HS-1:0];
  assign heat_en          = hs_q[7];
  assign ec_target        = hs_q[13:8];
  assign ec_on            = hs_q[14];
  assign ec_discharge     = hs_q[15];
  assign sense_sel        = sel_q;
  assign sense_in_mode    = mode_q;
  assign clr_flt_pulse    = clr_bit;
  assign wd_restart_pulse = wd_pls;

  always_comb begin
    rdata = '0;
    if (addr == IC_ADDR) rdata = {2'b00, mode_q, sel_q, key, 3'b000, wd_bit, clr_bit};
    if (addr == HB_ADDR) rdata = hb_q;
    if (addr == HS_ADDR) rdata = hs_q;
    for (int i = 0; i < N_DUTY; i++)
      if (addr == ADDR_W'(DUTY_BASE + i)) rdata = 16'(duty_q[i]);
  end
endmodule

module ctl_reg_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int N_HB = 6,
  parameter int N_DUTY = 6,
  parameter int DUTY_W = 10,
  parameter logic [ADDR_W-1:0] IC_ADDR = 8'h29,
  parameter logic [ADDR_W-1:0] HB_ADDR = 8'h2A,
  parameter logic [ADDR_W-1:0] DUTY_BASE = 8'h2C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic [N_HB-1:0]   hb_hs_on,
  input logic [N_HB-1:0]   hb_ls_on,
  input logic              clr_flt_pulse,
  input logic              wd_restart_pulse,
  input logic              locked,
  input logic              wd_bit,
  input logic [15:0]       hb_q
);
  logic in_duty, in_map;
  assign in_duty = (addr >= DUTY_BASE) && (32'(addr) < 32'(DUTY_BASE) + N_DUTY);
  assign in_map  = in_duty || (addr >= IC_ADDR && addr <= ADDR_W'(IC_ADDR + 2));

  AST_HB_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_hs_on & hb_ls_on) == '0); // R8
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && wr_en && addr == HB_ADDR && locked) |-> $stable(hb_q)); // R3
  AST_KEY_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && wr_en && addr == IC_ADDR && wdata[7:5] != 3'b011 && wdata[7:5] != 3'b110)
    |-> $stable(locked)); // R4
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flt_pulse == $past(rst_n && wr_en && addr == IC_ADDR && wdata[0])); // R5
  AST_WD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_restart_pulse == $past(rst_n && wr_en && addr == IC_ADDR && wdata[1] != wd_bit)); // R6
  AST_DUTY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_duty |-> rdata[15:DUTY_W] == '0); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !in_map |-> rdata == '0); // R9
endmodule

bind ctl_reg_bank ctl_reg_bank_chk #(
  .ADDR_W(ADDR_W), .N_HB(N_HB), .N_DUTY(N_DUTY), .DUTY_W(DUTY_W),
  .IC_ADDR(IC_ADDR), .HB_ADDR(HB_ADDR), .DUTY_BASE(DUTY_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .hb_hs_on(hb_hs_on), .hb_ls_on(hb_ls_on),
  .clr_flt_pulse(clr_flt_pulse), .wd_restart_pulse(wd_restart_pulse),
  .locked(locked), .wd_bit(wd_bit), .hb_q(hb_q)
);

// File: tb/tb_ctl_reg_bank.sv
module tb_ctl_reg_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic [5:0] hb_hs_on, hb_ls_on, hs_en, ec_target;
  logic [1:0] gd_hiz, gd_in;
  logic heat_en, ec_on, ec_discharge, sense_in_mode, clr_flt_pulse, wd_restart_pulse;
  logic [59:0] duty_flat;
  logic [4:0] sense_sel;

  int n_tests = 0;
  int n_fail = 0;

  ctl_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .hb_hs_on(hb_hs_on), .hb_ls_on(hb_ls_on), .gd_hiz(gd_hiz), .gd_in(gd_in),
    .hs_en(hs_en), .heat_en(heat_en), .ec_on(ec_on), .ec_discharge(ec_discharge),
    .ec_target(ec_target), .duty_flat(duty_flat), .sense_sel(sense_sel),
    .sense_in_mode(sense_in_mode), .clr_flt_pulse(clr_flt_pulse),
    .wd_restart_pulse(wd_restart_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model
  bit m_locked, m_wd, m_clr, m_wdp, m_mode;
  int m_key, m_sel, m_hb, m_hs;
  int m_duty [6];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_locked <= 0; m_key <= 3; m_wd <= 0; m_clr <= 0; m_wdp <= 0;
      m_sel <= 0; m_mode <= 0; m_hb <= 0; m_hs <= 0;
      for (int i = 0; i < 6; i++) m_duty[i] <= 0;
    end else begin
      m_clr <= 0; m_wdp <= 0;
      if (wr_en) begin
        if (addr == 8'h29) begin
          int k;
          k = (wdata >> 5) & 7;
          if (k == 3) begin m_key <= 3; m_locked <= 0; end
          if (k == 6) begin m_key <= 6; m_locked <= 1; end
          m_clr <= wdata[0];
          m_wdp <= (wdata[1] != m_wd);
          m_wd <= wdata[1];
          m_sel <= (wdata >> 8) & 31;
          m_mode <= wdata[13];
        end else if (!m_locked) begin
          if (addr == 8'h2A) m_hb <= wdata;
          if (addr == 8'h2B) m_hs <= wdata;
          if (addr >= 8'h2C && addr <= 8'h31) m_duty[addr - 8'h2C] <= wdata & 16'h3FF;
        end
      end
    end
  end

  function automatic int exp_rd(input int a);
    if (a == 'h29) return (m_mode << 13) | (m_sel << 8) | (m_key << 5) | (m_wd << 1) | m_clr;
    if (a == 'h2A) return m_hb;
    if (a == 'h2B) return m_hs;
    if (a >= 'h2C && a <= 'h31) return m_duty[a - 'h2C];
    return 0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      int hs, ls;
      logic [59:0] d;
      hs = 0; ls = 0;
      for (int k = 0; k < 6; k++) begin
        if (((m_hb >> (2*k)) & 3) == 1) hs |= (1 << k);
        if (((m_hb >> (2*k)) & 3) == 2) ls |= (1 << k);
      end
      for (int i = 0; i < 6; i++) d[i*10 +: 10] = m_duty[i][9:0];
      check("R1 rdata", rdata, exp_rd(addr));
      check("R8 hs", hb_hs_on, hs);
      check("R8 ls", hb_ls_on, ls);
      check("R7 duty", duty_flat, d);
      check("R5 clr", clr_flt_pulse, m_clr);
      check("R6 wd", wd_restart_pulse, m_wdp);
      check("R10 hs", {ec_discharge, ec_on, ec_target, heat_en, hs_en, gd_hiz, gd_in},
            {m_hs[15], m_hs[14], m_hs[13:8], m_hs[7], m_hs[5:0], m_hb[15:14], m_hb[13:12]});
      check("R10 sense", {sense_in_mode, sense_sel}, {m_mode, m_sel[4:0]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h29, 16'h0060, "R2 ic reset");
    rd(8'h2A, 16'h0000, "R2 hb reset");
    rd(8'h31, 16'h0000, "R2 duty reset");

    wr(8'h2A, 16'h9279); #1;
    check("R8 hs decode", hb_hs_on, 6'b001001);
    check("R8 ls decode", hb_ls_on, 6'b010010);
    rd(8'h2A, 16'h9279, "R1 hb readback");

    wr(8'h2B, 16'hFFFF); #1;
    check("R10 outputs", {hs_en, heat_en, ec_target, ec_on, ec_discharge}, {6'h3F, 1'b1, 6'h3F, 1'b1, 1'b1});
    rd(8'h2B, 16'hFFFF, "R1 hs readback");

    wr(8'h2C, 16'hFFFF);
    rd(8'h2C, 16'h03FF, "R7 duty0 upper zero");
    wr(8'h31, 16'h0155); #1;
    check("R7 duty5 field", duty_flat[59:50], 10'h155);
    rd(8'h31, 16'h0155, "R7 duty5 readback");

    wr(8'h32, 16'hFFFF);
    rd(8'h32, 16'h0000, "R9 above window");
    rd(8'h28, 16'h0000, "R9 below window");
    rd(8'h2B, 16'hFFFF, "R9 no alias");

    wr(8'h29, 16'h00C0);
    rd(8'h29, 16'h00C0, "R4 lock key readback");
    wr(8'h2A, 16'h0000); #1;
    check("R3 hb held", hb_hs_on, 6'b001001);
    rd(8'h2A, 16'h9279, "R3 hb locked");
    wr(8'h2C, 16'h0000);
    rd(8'h2C, 16'h03FF, "R3 duty locked");

    wr(8'h29, 16'h34E0); #1;
    check("R4 ic writable while locked", sense_sel, 5'h14);
    rd(8'h29, 16'h34C0, "R4 bad key ignored");
    wr(8'h2A, 16'h0000);
    rd(8'h2A, 16'h9279, "R4 still locked");

    wr(8'h29, 16'h0060);
    wr(8'h2A, 16'h0000);
    rd(8'h2A, 16'h0000, "R4 unlocked write");

    wr(8'h29, 16'h0060); #1;
    check("R6 same value no pulse", wd_restart_pulse, 1'b0);
    wr(8'h29, 16'h0062); #1;
    check("R6 toggle to 1 pulse", wd_restart_pulse, 1'b1);
    rd(8'h29, 16'h0062, "R6 value kept");
    wr(8'h29, 16'h0062); #1;
    check("R6 repeat no pulse", wd_restart_pulse, 1'b0);
    wr(8'h29, 16'h0060); #1;
    check("R6 toggle to 0 pulse", wd_restart_pulse, 1'b1);

    wr(8'h29, 16'h0061); #1;
    check("R5 pulse high", clr_flt_pulse, 1'b1);
    check("R5 bit reads one", rdata, 16'h0061);
    @(negedge clk); #1;
    check("R5 pulse gone", clr_flt_pulse, 1'b0);
    check("R5 bit self clears", rdata, 16'h0060);

    wr(8'h29, 16'h00C0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(8'h29, 16'h0060, "R2 reset unlocks");
    rd(8'h2C, 16'h0000, "R2 duty cleared");
    wr(8'h2C, 16'h0ABC);
    rd(8'h2C, 16'h02BC, "R2 writable after reset");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule